// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger Shaper

This block takes one interrupt request at a time from a PCI device. The device is identified by its slot number and by its interrupt pin, numbered 0 to 3 for INTA to INTD. The block routes that request to one of the bridge's internal interrupt lines. Those lines are numbered from a base of 32. Each line has one bit in an edge-select word and one bit in a polarity word. Bit k of either word configures line 32+k.

A change of the request level is an event. When an event arrives, the block looks up the routed line's configuration and shapes the CPU interrupt output from it:

- **Edge mode (edge bit set):** a rising request produces a one-cycle pulse.
- **Level mode (edge bit clear):** the output is set to the line's polarity bit and holds that value until the next event.

Requests from slots that have no route never reach the line range, so they leave the output alone.

The routing table is fixed:

- Slot 5 carries a multi-function on-board device. Each of its pins gets its own line.
- Slots 6 and 7 each have a single fixed line, whatever the pin.
- Add-in slots 8 to 12 rotate the pin onto a line that moves up with the slot number.

Top module: `irq_router_shaper`

## Requirements
- R1: While reset is asserted and right after it is released, `cpu_irq_o` is 0.
- R2: Slot 5 with pin p (0 to 3) is routed to line 32+p, which is configured by bit p of the edge and polarity words.
- R3: Slot 6 is routed to line 36 (bit 4) and slot 7 to line 37 (bit 5), for every pin.
- R4: Slot s in 8 to 12 with pin p is routed to line 38+(s-8)+p, which is bit 6+(s-8)+p.
- R5: For any other slot, the pin number passes through unchanged as the line number, which lies below the base. Such a request changes neither the output nor the shaping state, in either mode.
- R6: In edge mode, a rising request on a routed line makes `cpu_irq_o` high for exactly one cycle, starting one clock after the edge is sampled. Afterwards the output is 0, even if it was held high by level mode before.
- R7: In edge mode, a falling request produces no pulse and leaves the output unchanged.
- R8: In level mode, any change of the request on a routed line sets `cpu_irq_o`, one clock later, to that line's polarity bit (1 drives high, 0 drives low). The output keeps that value until the next event.
- R9: While the request does not change, `cpu_irq_o` holds its value (apart from ending a pulse). This is true even when slot, pin, edge word or polarity word change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 5 | Slot number of the requesting device |
| pin_i | input | 2 | Interrupt pin of the requesting device, 0 = INTA to 3 = INTD |
| req_i | input | 1 | Request level; every change is an event |
| edge_cfg_i | input | 32 | Bit k set selects edge mode for line 32+k |
| pol_cfg_i | input | 32 | Bit k is the level-mode output value for line 32+k |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: a 5-bit slot number, a 2-bit pin, a base of 32 and 32 lines.

With these values the bench can reach every slot from 0 to 31. It covers each pin of every routed slot, including the top corner at slot 12, pin 3, which lands on line 45. It also covers all slots outside the routed range, where the pin passes through below the base.

The 32-bit edge and polarity words let a single set bit identify exactly which line a request reached.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Fixed slot assignments and their line offsets above the base.
  localparam int MULTI_SLOT = 5;   // multi-function device: one line per pin
  localparam int GFX_SLOT   = 6;
  localparam int NIC_SLOT   = 7;
  localparam int ADDIN_LO   = 8;
  localparam int ADDIN_HI   = 12;
  localparam int GFX_OFS    = 4;
  localparam int NIC_OFS    = 5;
  localparam int ADDIN_OFS  = 6;

  // Absolute line number for a slot/pin pair; unrouted slots pass the pin.
  function automatic int route_line(input int slot, input int pin, input int base);
    if (slot == MULTI_SLOT)
      return base + (pin % 4);
    else if (slot == GFX_SLOT)
      return base + GFX_OFS;
    else if (slot == NIC_SLOT)
      return base + NIC_OFS;
    else if (slot >= ADDIN_LO && slot <= ADDIN_HI)
      return base + ADDIN_OFS + (slot - ADDIN_LO) + pin;
    else
      return pin;
  endfunction

  function automatic bit slot_routed(input int slot);
    return (slot >= MULTI_SLOT) && (slot <= ADDIN_HI);
  endfunction

endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle #(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int IRQ_BASE  = 32,
  parameter int NUM_LINES = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [IDX_W-1:0]  line_idx_o,
  output logic              line_ok_o
);
  import irq_route_pkg::*;

  int line_num;
  int line_rel;

  always_comb begin
    line_num   = route_line(int'(slot_i), int'(pin_i), IRQ_BASE);
    line_rel   = line_num - IRQ_BASE;
    line_ok_o  = (line_rel >= 0) && (line_rel < NUM_LINES);
    line_idx_o = line_ok_o ? IDX_W'(line_rel) : '0;
  end

endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic chg_o,
  output logic rise_o
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_i;
  end

  assign chg_o  = req_i ^ req_q;
  assign rise_o = req_i & ~req_q;

endmodule

// File: rtl/irq_shaper.sv
module irq_shaper #(
  parameter int NUM_LINES = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_i,
  input  logic                 rise_i,
  input  logic                 line_ok_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_LINES-1:0] edge_cfg_i,
  input  logic [NUM_LINES-1:0] pol_cfg_i,
  output logic                 irq_o
);
  logic level_q, pulse_q;
  logic edge_bit, pol_bit, hit;

  assign edge_bit = edge_cfg_i[idx_i];
  assign pol_bit  = pol_cfg_i[idx_i];
  assign hit      = evt_i & line_ok_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (hit) begin
        if (!edge_bit) begin
          level_q <= pol_bit;
        end else if (rise_i) begin
          pulse_q <= 1'b1;
          level_q <= 1'b0;   // a pulse ends low
        end
      end
    end
  end

  assign irq_o = level_q | pulse_q;

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rise_i && edge_bit) |=> irq_o);
  a_r7_fall_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rise_i && edge_bit) |=> (!pulse_q && $stable(irq_o)));
  a_r8_level_pol: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !edge_bit) |=> (irq_o == $past(pol_bit)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !pulse_q) |=> $stable(irq_o));

endmodule

// File: rtl/irq_router_shaper.sv
module irq_router_shaper #(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int IRQ_BASE  = 32,
  parameter int NUM_LINES = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [PIN_W-1:0]     pin_i,
  input  logic                 req_i,
  input  logic [NUM_LINES-1:0] edge_cfg_i,
  input  logic [NUM_LINES-1:0] pol_cfg_i,
  output logic                 cpu_irq_o
);
  import irq_route_pkg::*;

  logic [IDX_W-1:0] line_idx;
  logic             line_ok;
  logic             req_chg, req_rise;

  irq_swizzle #(
    .SLOT_W(SLOT_W), .PIN_W(PIN_W), .IRQ_BASE(IRQ_BASE), .NUM_LINES(NUM_LINES)
  ) u_swizzle (
    .slot_i(slot_i), .pin_i(pin_i), .line_idx_o(line_idx), .line_ok_o(line_ok)
  );

  irq_event_detect u_evt (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .chg_o(req_chg), .rise_o(req_rise)
  );

  irq_shaper #(.NUM_LINES(NUM_LINES)) u_shaper (
    .clk(clk), .rst_n(rst_n), .evt_i(req_chg), .rise_i(req_rise),
    .line_ok_i(line_ok), .idx_i(line_idx),
    .edge_cfg_i(edge_cfg_i), .pol_cfg_i(pol_cfg_i), .irq_o(cpu_irq_o)
  );

  // R5: unrouted slots never reach the line range
  a_r5_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_routed(int'(slot_i)) |-> !line_ok);
  // R3: fixed on-board slots land on their single line
  a_r3_fixed_line: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_i) == GFX_SLOT) |-> (line_ok && int'(line_idx) == GFX_OFS));
  // R5: a request from an unrouted slot leaves the output untouched
  a_r5_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_ok && !cpu_irq_o) |=> !cpu_irq_o || $past(req_chg && line_ok));

endmodule

// File: tb/test_irq_router_shaper.sv
module test_irq_router_shaper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  slot;
  logic [1:0]  pin;
  logic        req;
  logic [31:0] edge_w, pol_w;
  logic        cpu_irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_router_shaper i_irq_router_shaper (
    .clk(clk), .rst_n(rst_n), .slot_i(slot), .pin_i(pin), .req_i(req),
    .edge_cfg_i(edge_w), .pol_cfg_i(pol_w), .cpu_irq_o(cpu_irq)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  // Expected bit index per the routing requirements, -1 if unrouted
  function automatic int exp_bit(input int s, input int p);
    case (s)
      5: return p;
      6: return 4;
      7: return 5;
      8, 9, 10, 11, 12: return s - 2 + p;
      default: return -1;
    endcase
  endfunction

  // Flip request with given slot/pin; return after output has registered
  task automatic toggle(input int s, input int p);
    @(negedge clk);
    slot = 5'(s); pin = 2'(p); req = ~req;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cpu_irq, 1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_irq, 1'b0, "R1 after release");
  endtask

  task automatic t_map(input int s, input int p, input string tag);
    int k;
    k = exp_bit(s, p);
    edge_w = 32'h0;
    pol_w  = 32'(1) << k;
    toggle(s, p);
    chk(cpu_irq, 1'b1, $sformatf("%s slot %0d pin %0d bit %0d high", tag, s, p, k));
    pol_w = ~(32'(1) << k);
    toggle(s, p);
    chk(cpu_irq, 1'b0, $sformatf("%s slot %0d pin %0d bit %0d low", tag, s, p, k));
  endtask

  task automatic t_unrouted();
    edge_w = 32'h0; pol_w = 32'h10;
    toggle(6, 0);
    chk(cpu_irq, 1'b1, "R5 setup high");
    pol_w = 32'h0;
    for (int s = 0; s < 32; s++) begin
      if (exp_bit(s, 0) < 0) begin
        toggle(s, s % 4);
        chk(cpu_irq, 1'b1, $sformatf("R5 level slot %0d ignored", s));
      end
    end
    edge_w = 32'hFFFF_FFFF;
    for (int i = 0; i < 4; i++) begin
      toggle(3, i);
      chk(cpu_irq, 1'b1, $sformatf("R5 edge slot 3 pin %0d ignored", i));
    end
  endtask

  task automatic t_edge_rise();
    edge_w = 32'h0; pol_w = 32'hFFFF_FFFF;
    toggle(6, 0);
    if (req) toggle(6, 0);
    chk(cpu_irq, 1'b1, "R6 setup level high");
    edge_w = 32'h10;
    toggle(6, 0);
    chk(cpu_irq, 1'b1, "R6 pulse high");
    @(negedge clk);
    chk(cpu_irq, 1'b0, "R6 pulse one cycle, level cleared");
    @(negedge clk);
    chk(cpu_irq, 1'b0, "R6 stays low");
  endtask

  task automatic t_edge_fall();
    edge_w = 32'h0; pol_w = 32'hFFFF_FFFF;
    toggle(7, 1);
    if (!req) toggle(7, 1);
    chk(cpu_irq, 1'b1, "R7 setup level high");
    edge_w = 32'h20;
    toggle(7, 1);
    chk(cpu_irq, 1'b1, "R7 fall leaves output");
    @(negedge clk);
    chk(cpu_irq, 1'b1, "R7 no pulse afterwards");
  endtask

  task automatic t_hold();
    edge_w = 32'h0; pol_w = 32'(1) << 10;
    toggle(9, 3);
    chk(cpu_irq, 1'b1, "R8 level high on bit 10");
    pol_w = 32'h0; edge_w = 32'hFFFF_FFFF; slot = 5'd12; pin = 2'd1;
    repeat (5) @(negedge clk);
    chk(cpu_irq, 1'b1, "R9 held without event");
    edge_w = 32'h0;
    toggle(9, 3);
    chk(cpu_irq, 1'b0, "R8 level low by polarity 0");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; slot = '0; pin = '0; edge_w = '0; pol_w = '0;
    repeat (3) @(negedge clk);
    t_reset();
    for (int p = 0; p < 4; p++) t_map(5, p, "R2");
    for (int p = 0; p < 4; p++) t_map(6, p, "R3");
    for (int p = 0; p < 4; p++) t_map(7, p, "R3");
    for (int s = 8; s <= 12; s++)
      for (int p = 0; p < 4; p++) t_map(s, p, "R4");
    t_unrouted();
    t_edge_rise();
    t_edge_fall();
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule